// File: doc/BRIEF.md
# Interlocked Asynchronous Read Master

This block performs single-word memory reads over a bus that carries no clock. Each step of a read is set off by the event before it. The master first puts the address on the bus and raises a read strobe. It then waits a fixed number of local clock cycles so that those lines can settle, and only then raises its request strobe. The slave starts its access when it sees the request. It raises its reply strobe only once valid data sits on the data lines. When the master sees the reply, it captures the data and drops its request and read strobes. It then waits for the slave to drop the reply before it will accept another read.

Because nothing on the bus is clocked, the length of a read depends only on how long the slave takes to answer. The reply strobe comes from another timing domain, so it passes through a chain of synchronizing flops before the control logic uses it. If no reply arrives within a set window, the master gives up, releases the bus and reports a timeout. A local client starts a read with a one-cycle start pulse carrying the address. It learns the result from a done pulse or a timeout pulse.

Top module: `async_rd_master`

## Requirements
- R1: While reset is held and after it is released, bus_msyn, bus_rd, busy, done and timeout are 0 and rd_data is 0.
- R2: A start pulse sampled while the block is idle drives bus_addr to start_addr and raises bus_rd and busy at that same edge, with bus_msyn still low. bus_addr holds its value for as long as bus_rd is high.
- R3: bus_msyn rises exactly SETTLE_CYC clock edges after bus_rd rises, and bus_msyn is never high while bus_rd is low.
- R4: bus_ssyn passes through SYNC_STAGES flops before it is used. With the default of 2 stages, at the third edge after bus_ssyn rises the block captures bus_data into rd_data, pulses done high for one cycle, and drops bus_msyn and bus_rd.
- R5: After a read ends, busy stays high and no new read can start until the synchronized bus_ssyn is seen low. busy falls at the third edge after bus_ssyn falls.
- R6: If the synchronized bus_ssyn has not been seen by the TIMEOUT_CYC-th edge after bus_msyn rises, the block drops bus_msyn and bus_rd at that edge and pulses timeout for one cycle. In that case it gives no done pulse and leaves rd_data unchanged. A reply first seen at exactly that edge completes normally, and done and timeout are never high together.
- R7: A start pulse that arrives while busy is high is ignored. bus_rd does not rise in response to it.
- R8: The number of cycles from start to done grows one for one with the slave's reply delay, with no fixed bus period: done is due SETTLE_CYC + delay + 3 edges after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock of the master |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a read |
| start_addr | input | ADDR_W | Address for the requested read |
| busy | output | 1 | A read or its release phase is in progress |
| done | output | 1 | One-cycle pulse: rd_data holds new data |
| rd_data | output | DATA_W | Last word captured from the bus |
| timeout | output | 1 | One-cycle pulse: the slave did not answer in time |
| bus_addr | output | ADDR_W | Address lines to the slave |
| bus_rd | output | 1 | Read command line |
| bus_msyn | output | 1 | Master request strobe |
| bus_ssyn | input | 1 | Slave reply strobe, asynchronous |
| bus_data | input | DATA_W | Data lines from the slave |

## Verification
Address and read strobe are due at the start edge itself. The request strobe is due SETTLE_CYC edges later. Capture, done and the strobe drop are due on the third edge after the reply rises, and idle is due on the third edge after the reply falls. A timeout is due TIMEOUT_CYC edges after the request rises. A behavioural reference model in the bench is updated at each rising edge from the sampled inputs, and every output is compared with it at the following falling edge. The slave in the bench changes its reply strobe 2 ns after a rising edge, so each change is counted from the next edge. Directed checks count falling edges from start to done or timeout for reply delays of 0, 5, 12, 13 and 14 cycles. The 13 and 14 cycle cases sit on either side of the timeout edge.

// File: rtl/async_rd_pkg.sv
package async_rd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETTLE  = 2'd1,
        PH_WAIT    = 2'd2,
        PH_RELEASE = 2'd3
    } rd_phase_e;

endpackage

// File: rtl/async_rd_sync.sv
module async_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_d[g] = async_i;
        end else begin : g_next
            assign chain_d[g] = chain_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/async_rd_cnt.sv
module async_rd_cnt #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [CW-1:0] limit_i,
    output logic          at_limit_o
);
    logic [CW-1:0] count_d;
    logic [CW-1:0] count_q;

    always_comb begin
        count_d = clr_i ? '0 : count_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign at_limit_o = (count_q == limit_i);

    // R6
    cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr_i) && count_q != '0) |-> count_q == $past(count_q) + CW'(1));
endmodule

// File: rtl/async_rd_fsm.sv
module async_rd_fsm
    import async_rd_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int SETTLE_CYC  = 2,
    parameter int TIMEOUT_CYC = 16,
    parameter int CW          = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              ssyn_s_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              at_limit_i,
    output logic              cnt_clr_o,
    output logic [CW-1:0]     cnt_limit_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_rd_o,
    output logic              bus_msyn_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              tmo_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam logic [CW-1:0] SETTLE_LIM  = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] TIMEOUT_LIM = CW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        rd_phase_e         ph;
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              msyn;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              tmo;
    } ctl_t;

    ctl_t s_d;
    ctl_t s_q;

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.tmo     = 1'b0;
        cnt_clr_o   = 1'b0;
        cnt_limit_o = (s_q.ph == PH_SETTLE) ? SETTLE_LIM : TIMEOUT_LIM;
        case (s_q.ph)
            PH_IDLE: begin
                cnt_clr_o = 1'b1;
                if (start_i) begin
                    s_d.addr = start_addr_i;
                    s_d.rd   = 1'b1;
                    s_d.ph   = PH_SETTLE;
                end
            end
            PH_SETTLE: begin
                if (at_limit_i) begin
                    s_d.msyn  = 1'b1;
                    s_d.ph    = PH_WAIT;
                    cnt_clr_o = 1'b1;
                end
            end
            PH_WAIT: begin
                if (ssyn_s_i) begin
                    s_d.data  = data_i;
                    s_d.msyn  = 1'b0;
                    s_d.rd    = 1'b0;
                    s_d.done  = 1'b1;
                    s_d.ph    = PH_RELEASE;
                    cnt_clr_o = 1'b1;
                end else if (at_limit_i) begin
                    s_d.msyn  = 1'b0;
                    s_d.rd    = 1'b0;
                    s_d.tmo   = 1'b1;
                    s_d.ph    = PH_RELEASE;
                    cnt_clr_o = 1'b1;
                end
            end
            PH_RELEASE: begin
                cnt_clr_o = 1'b1;
                if (!ssyn_s_i) s_d.ph = PH_IDLE;
            end
            default: begin
                cnt_clr_o = 1'b1;
                s_d.ph    = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, addr: '0, rd: 1'b0, msyn: 1'b0,
                             data: '0, done: 1'b0, tmo: 1'b0};
        else        s_q <= s_d;
    end

    assign bus_addr_o = s_q.addr;
    assign bus_rd_o   = s_q.rd;
    assign bus_msyn_o = s_q.msyn;
    assign busy_o     = (s_q.ph != PH_IDLE);
    assign done_o     = s_q.done;
    assign tmo_o      = s_q.tmo;
    assign rd_data_o  = s_q.data;

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_o && $past(bus_rd_o)) |-> $stable(bus_addr_o));
    // R3
    msyn_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_msyn_o |-> bus_rd_o);
    // R3
    msyn_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_msyn_o) |-> $past(bus_rd_o));
    // R4
    done_from_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(ssyn_s_i) && !bus_msyn_o);
    // R5
    no_start_on_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd_o) |-> !$past(ssyn_s_i));
    // R6
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && tmo_o));
    // R6
    msyn_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_msyn_o) |-> (done_o || tmo_o));
endmodule

// File: rtl/async_rd_master.sv
module async_rd_master #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int SETTLE_CYC  = 2,
    parameter int TIMEOUT_CYC = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              timeout,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_msyn,
    input  logic              bus_ssyn,
    input  logic [DATA_W-1:0] bus_data
);
    localparam int LIM_MAX = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
    localparam int CW      = $clog2(LIM_MAX + 1);

    logic          ssyn_s;
    logic          cnt_clr;
    logic [CW-1:0] cnt_limit;
    logic          at_limit;

    async_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (bus_ssyn),
        .sync_o  (ssyn_s)
    );

    async_rd_cnt #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (cnt_clr),
        .limit_i    (cnt_limit),
        .at_limit_o (at_limit)
    );

    async_rd_fsm #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SETTLE_CYC  (SETTLE_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .CW          (CW)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .start_addr_i (start_addr),
        .ssyn_s_i     (ssyn_s),
        .data_i       (bus_data),
        .at_limit_i   (at_limit),
        .cnt_clr_o    (cnt_clr),
        .cnt_limit_o  (cnt_limit),
        .bus_addr_o   (bus_addr),
        .bus_rd_o     (bus_rd),
        .bus_msyn_o   (bus_msyn),
        .busy_o       (busy),
        .done_o       (done),
        .tmo_o        (timeout),
        .rd_data_o    (rd_data)
    );
endmodule

// File: tb/sim_async_rd_master.sv
`timescale 1ns/1ps
module sim_async_rd_master;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int SETTLE = 2;
    localparam int TO = 16;
    localparam int SYN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic busy, done, timeout, bus_rd, bus_msyn;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] bus_addr;
    logic bus_ssyn = 1'b0;
    logic [DW-1:0] bus_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    int slv_dly = 0;
    int slv_rel = 0;
    bit slv_mute = 1'b0;

    always #2.5 clk = ~clk;

    async_rd_master #(.ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(SETTLE),
                      .TIMEOUT_CYC(TO), .SYNC_STAGES(SYN)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .busy(busy), .done(done), .rd_data(rd_data), .timeout(timeout),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_msyn(bus_msyn),
        .bus_ssyn(bus_ssyn), .bus_data(bus_data));

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural slave: answers after slv_dly edges, holds reply slv_rel edges past release
    initial begin
        forever begin
            @(posedge bus_msyn);
            if (!slv_mute) begin
                repeat (slv_dly) @(posedge clk);
                #1 bus_data = word_of(bus_addr);
                #1 bus_ssyn = 1'b1;
                wait (bus_msyn == 1'b0);
                repeat (slv_rel) @(posedge clk);
                @(posedge clk);
                #2 bus_ssyn = 1'b0;
            end
        end
    end

    // reference model
    int m_ph = 0;
    int m_cnt = 0;
    bit m_rd = 0, m_msyn = 0, m_done = 0, m_tmo = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;
    bit sq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_rd = 0; m_msyn = 0; m_done = 0; m_tmo = 0;
            m_addr = '0; m_data = '0;
            sq = {};
            for (int i = 0; i < SYN; i++) sq.push_back(1'b0);
        end else begin
            bit seen;
            seen = sq[SYN-1];
            m_done = 0; m_tmo = 0;
            if (m_ph == 0) begin
                if (start) begin m_addr = start_addr; m_rd = 1; m_ph = 1; m_cnt = 0; end
            end else if (m_ph == 1) begin
                m_cnt++;
                if (m_cnt == SETTLE) begin m_msyn = 1; m_ph = 2; m_cnt = 0; end
            end else if (m_ph == 2) begin
                m_cnt++;
                if (seen) begin
                    m_data = bus_data; m_msyn = 0; m_rd = 0; m_done = 1; m_ph = 3;
                end else if (m_cnt == TO) begin
                    m_msyn = 0; m_rd = 0; m_tmo = 1; m_ph = 3;
                end
            end else begin
                if (!seen) m_ph = 0;
            end
            sq.push_front(bus_ssyn);
            void'(sq.pop_back());
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(bus_msyn === m_msyn, "R3 bus_msyn", int'(bus_msyn), int'(m_msyn));
            check(bus_rd === m_rd, "R2 bus_rd", int'(bus_rd), int'(m_rd));
            check(busy === (m_ph != 0), "R5 busy", int'(busy), int'(m_ph != 0));
            check(done === m_done, "R4 done", int'(done), int'(m_done));
            check(timeout === m_tmo, "R6 timeout", int'(timeout), int'(m_tmo));
            check(rd_data === m_data, "R4 rd_data", int'(rd_data), int'(m_data));
            if (m_rd) check(bus_addr === m_addr, "R2 bus_addr", int'(bus_addr), int'(m_addr));
        end
    end

    task automatic do_read(input logic [AW-1:0] a, input int dly, input int rel,
                           input bit mute, input bit poke);
        int k;
        logic [DW-1:0] prev;
        prev = rd_data;
        slv_dly = dly; slv_rel = rel; slv_mute = mute;
        @(negedge clk);
        start = 1'b1; start_addr = a;
        @(negedge clk);
        start = 1'b0;
        // R2: address and read strobe right after the start edge, request still low
        check(bus_rd === 1'b1 && bus_addr === a && bus_msyn === 1'b0, "R2 launch",
              int'(bus_addr), int'(a));
        k = 0;
        while (!done && !timeout && k < 200) begin
            @(negedge clk);
            k++;
        end
        if (mute || dly > TO - 3) begin
            // R6: timeout edge counted from start, data untouched
            check(timeout === 1'b1 && k == SETTLE + TO, "R6 timeout edge", k, SETTLE + TO);
            check(rd_data === prev, "R6 rd_data kept", int'(rd_data), int'(prev));
        end else begin
            // R8: length follows the slave delay; R4: captured word
            check(done === 1'b1 && k == SETTLE + dly + 3, "R8 done edge", k, SETTLE + dly + 3);
            check(rd_data === word_of(a), "R4 data word", int'(rd_data), int'(word_of(a)));
        end
        if (poke) begin
            start = 1'b1; start_addr = ~a;
            @(negedge clk);
            start = 1'b0;
            // R7: start during release does nothing
            check(bus_rd === 1'b0 && busy === 1'b1, "R7 ignored start", int'(bus_rd), 0);
        end
        k = 0;
        while (busy && k < 200) begin @(negedge clk); k++; end
        check(busy === 1'b0, "R5 back to idle", int'(busy), 0);
        check(bus_ssyn === 1'b0, "R5 idle after reply low", int'(bus_ssyn), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 0 && done === 0 && timeout === 0 && bus_msyn === 0 &&
              bus_rd === 0 && rd_data === '0, "R1 reset", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 0 && bus_rd === 0, "R1 after release", int'(busy), 0);
        do_read(8'h3C, 0, 0, 1'b0, 1'b0);
        do_read(8'hA5, 5, 3, 1'b0, 1'b1);
        do_read(8'hFF, 12, 0, 1'b0, 1'b0);
        do_read(8'h81, 13, 0, 1'b0, 1'b0);
        do_read(8'h42, 14, 0, 1'b0, 1'b0);
        do_read(8'h17, 0, 0, 1'b1, 1'b0);
        do_read(8'h00, 1, 6, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule